// File: doc/BRIEF.md
# SPI NOR Serial Flash Slave

This block is the slave side of a SPI NOR serial flash, built around a small on-chip byte array. A host master drives chip select, serial clock and data in. The block returns read data, the status byte and a device ID on its data output. The serial clock is oversampled by the block's own system clock. Either idle clock level (SPI mode 0 or mode 3) is accepted. Input bits are captured on rising serial-clock edges and output bits advance on the same edges. All bytes travel most significant bit first.

Program, erase and status-write commands are staged while chip select is low. They launch only when chip select returns high on an exact byte boundary. They then run as an internal cycle that moves one byte per system clock, so the time spent busy scales with the amount of storage touched. Page-program data is collected in a page-sized staging buffer with a per-byte valid mask. While the cycle runs the array is written as old AND new. Erase writes FFh over an aligned 512-byte sector or 1024-byte block. A deep power-down state silences everything except the release command, which returns the ID byte.

Top module: `spi_flash_slave`

## Requirements
- R1: After reset the status byte reads 00h and the device answers commands, so it is not in deep power-down.
- R2: Opcode 03h followed by a 24-bit address returns the stored bytes from that address onward, one per 8 clocks, with the address incrementing. Both mode 0 and mode 3 clocking work.
- R3: Status bit 0 is write-in-progress and bit 1 is write-enable. Opcode 06h sets bit 1 and opcode 04h clears it. Bits 7:2 are plain storage.
- R4: Opcode 05h returns the current status byte again on every following group of 8 clocks until chip select rises.
- R5: Page program (02h, address, data bytes) runs only when chip select rises after a whole number of data bytes. Otherwise the array is unchanged and write-enable stays set. Programming only clears bits: the result is old data AND new data.
- R6: Program data that runs past the end of a 256-byte page continues at the byte of the same page whose low 8 address bits are zero.
- R7: Sector erase (20h) and block erase (D8h) set an aligned 512-byte or 1024-byte region to FFh. They run only when chip select rises right after the eighth bit of the third address byte.
- R8: Program, erase and status write are discarded when write-enable is clear.
- R9: While a cycle runs, status bit 0 reads 1 and only opcode 05h is honoured. Toggling chip select does not abort the cycle. At its end both bit 0 and bit 1 read 0.
- R10: Opcode B9h enters deep power-down, where every opcode except ABh is ignored. ABh leaves deep power-down and returns the 8-bit device ID (13h by default) repeatedly. B9h issued during a cycle is ignored.
- R11: Status write (01h, one data byte) loads bits 7:2 from the data byte at the end of its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial interface |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |

## Verification
A wrong write-enable or busy flag shows up in the next status read, within one command of the fault. A wrong staging mask, wrap pointer or erase base shows up only when the affected bytes are read back after the cycle. For that reason, every program and erase check reads both the touched bytes and a neighbour outside the intended range. The deep power-down state can only be seen as silence: the bench sets write-enable before entering it, so an ignored status read returns 00h where a live one would return 02h.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;
    typedef enum logic [2:0] {
        PH_OP, PH_ADDR, PH_STREAM, PH_PROG, PH_WRSR, PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        ENG_IDLE, ENG_PROG, ENG_ERASE, ENG_STAT
    } eng_e;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_PP   = 8'h02;
    localparam logic [7:0] OP_SE   = 8'h20;
    localparam logic [7:0] OP_BE   = 8'hD8;
    localparam logic [7:0] OP_DP   = 8'hB9;
    localparam logic [7:0] OP_RES  = 8'hAB;
endpackage

// File: rtl/spi_flash_rx.sv
module spi_flash_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_i,
    input  logic       cs_n_i,
    input  logic       mosi_i,
    output logic       sel,
    output logic       rise,
    output logic       byte_done,
    output logic       cs_rise,
    output logic [7:0] rx_byte
);
    logic [2:0] sck_q, cs_q;
    logic [1:0] mosi_q;
    logic [6:0] sr_q, sr_d;
    logic [2:0] cnt_q, cnt_d;

    assign sel       = ~cs_q[1];
    assign rise      = sel & sck_q[1] & ~sck_q[2];
    assign byte_done = rise & (cnt_q == 3'd7);
    assign cs_rise   = cs_q[1] & ~cs_q[2];
    assign rx_byte   = {sr_q, mosi_q[1]};

    always_comb begin
        sr_d  = sr_q;
        cnt_d = cnt_q;
        if (!sel) begin
            cnt_d = '0;
        end else if (rise) begin
            cnt_d = cnt_q + 3'd1;
            sr_d  = {sr_q[5:0], mosi_q[1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
            sr_q   <= '0;
            cnt_q  <= '0;
        end else begin
            sck_q  <= {sck_q[1:0], sck_i};
            cs_q   <= {cs_q[1:0], cs_n_i};
            mosi_q <= {mosi_q[0], mosi_i};
            sr_q   <= sr_d;
            cnt_q  <= cnt_d;
        end
    end
endmodule

// File: rtl/spi_flash_ram.sv
module spi_flash_ram #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/spi_flash_slave.sv
module spi_flash_slave
    import spi_flash_pkg::*;
#(
    parameter int         MEM_BYTES    = 2048,
    parameter int         PAGE_BYTES   = 256,
    parameter int         SECTOR_BYTES = 512,
    parameter int         BLOCK_BYTES  = 1024,
    parameter int         STAT_CYCLES  = 300,
    parameter logic [7:0] DEV_ID       = 8'h13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic miso
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int CW = $clog2(MEM_BYTES + STAT_CYCLES) + 1;
    localparam logic [AW-1:0] SEC_MASK = AW'(SECTOR_BYTES - 1);
    localparam logic [AW-1:0] BLK_MASK = AW'(BLOCK_BYTES - 1);
    localparam logic [AW-1:0] PG_MASK  = AW'(PAGE_BYTES - 1);

    typedef struct packed {
        phase_e                ph;
        logic [7:0]            cmd;
        logic [1:0]            acnt;
        logic [AW-1:0]         addr;
        logic [7:0]            tx;
        logic                  arm;
        logic                  dp;
        logic                  wel;
        logic [5:0]            user;
        logic [5:0]            user_new;
        logic [PAGE_BYTES-1:0] mask;
        eng_e                  eng;
        logic [AW-1:0]         eptr;
        logic [CW-1:0]         eleft;
    } st_t;

    st_t s_q, s_d;

    logic          sel, rise, byte_done, cs_rise;
    logic [7:0]    rx;
    logic          busy, prog_active;
    logic [7:0]    status;
    logic [AW-1:0] addr_next, mem_raddr;
    logic [7:0]    mem_rdata, mem_wdata, pb_rdata;
    logic          mem_we, pb_we;

    spi_flash_rx i_rx (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi),
        .sel(sel), .rise(rise), .byte_done(byte_done), .cs_rise(cs_rise),
        .rx_byte(rx)
    );

    assign busy        = (s_q.eng != ENG_IDLE);
    assign prog_active = (s_q.eng == ENG_PROG);
    assign status      = {s_q.user, s_q.wel, busy};
    assign addr_next   = AW'({s_q.addr, rx});
    assign miso        = s_q.tx[7];

    always_comb begin
        if (busy)                  mem_raddr = s_q.eptr;
        else if (s_q.ph == PH_ADDR) mem_raddr = addr_next;
        else                        mem_raddr = s_q.addr;
    end

    assign mem_we    = prog_active ? s_q.mask[s_q.eptr[PW-1:0]] : (s_q.eng == ENG_ERASE);
    assign mem_wdata = (s_q.eng == ENG_ERASE) ? 8'hFF : (mem_rdata & pb_rdata);
    assign pb_we     = byte_done && (s_q.ph == PH_PROG);

    spi_flash_ram #(.DEPTH(MEM_BYTES)) i_array (
        .clk(clk), .we(mem_we), .waddr(s_q.eptr), .wdata(mem_wdata),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    spi_flash_ram #(.DEPTH(PAGE_BYTES)) i_pagebuf (
        .clk(clk), .we(pb_we), .waddr(s_q.addr[PW-1:0]), .wdata(rx),
        .raddr(s_q.eptr[PW-1:0]), .rdata(pb_rdata)
    );

    always_comb begin
        s_d = s_q;

        // internal cycle: one byte per clock
        if (busy) begin
            s_d.eptr  = s_q.eptr + 1'b1;
            s_d.eleft = s_q.eleft - 1'b1;
            if (s_q.eleft == CW'(1)) begin
                s_d.eng = ENG_IDLE;
                s_d.wel = 1'b0;
                if (s_q.eng == ENG_STAT) s_d.user = s_q.user_new;
            end
        end

        if (rise && !byte_done) begin
            s_d.arm = 1'b0;
            if (s_q.ph == PH_STREAM) s_d.tx = {s_q.tx[6:0], 1'b0};
        end

        if (byte_done) begin
            s_d.arm = 1'b0;
            s_d.tx  = '0;
            case (s_q.ph)
                PH_OP: begin
                    s_d.cmd = rx;
                    if ((s_q.dp && rx != OP_RES) || (busy && rx != OP_RDSR)) begin
                        s_d.ph = PH_SKIP;
                    end else begin
                        case (rx)
                            OP_WREN, OP_WRDI, OP_DP: begin
                                s_d.ph  = PH_SKIP;
                                s_d.arm = 1'b1;
                            end
                            OP_RDSR: begin
                                s_d.ph = PH_STREAM;
                                s_d.tx = status;
                            end
                            OP_WRSR: s_d.ph = PH_WRSR;
                            OP_READ, OP_SE, OP_BE: begin
                                s_d.ph   = PH_ADDR;
                                s_d.acnt = '0;
                            end
                            OP_PP: begin
                                s_d.ph   = PH_ADDR;
                                s_d.acnt = '0;
                                s_d.mask = '0;
                            end
                            OP_RES: begin
                                s_d.dp = 1'b0;
                                s_d.ph = PH_STREAM;
                                s_d.tx = DEV_ID;
                            end
                            default: s_d.ph = PH_SKIP;
                        endcase
                    end
                end
                PH_ADDR: begin
                    s_d.addr = addr_next;
                    s_d.acnt = s_q.acnt + 2'd1;
                    if (s_q.acnt == 2'd2) begin
                        case (s_q.cmd)
                            OP_READ: begin
                                s_d.ph   = PH_STREAM;
                                s_d.tx   = mem_rdata;
                                s_d.addr = addr_next + 1'b1;
                            end
                            OP_PP: s_d.ph = PH_PROG;
                            default: begin
                                s_d.ph  = PH_SKIP;
                                s_d.arm = 1'b1;
                            end
                        endcase
                    end
                end
                PH_PROG: begin
                    s_d.mask[s_q.addr[PW-1:0]] = 1'b1;
                    s_d.addr[PW-1:0] = s_q.addr[PW-1:0] + 1'b1;
                    s_d.arm = 1'b1;
                end
                PH_WRSR: begin
                    s_d.user_new = rx[7:2];
                    s_d.ph       = PH_SKIP;
                    s_d.arm      = 1'b1;
                end
                PH_STREAM: begin
                    case (s_q.cmd)
                        OP_READ: begin
                            s_d.tx   = mem_rdata;
                            s_d.addr = s_q.addr + 1'b1;
                        end
                        OP_RDSR: s_d.tx = status;
                        default: s_d.tx = DEV_ID;
                    endcase
                end
                default: ;
            endcase
        end

        // execution on deselect, only on a clean byte boundary
        if (cs_rise && s_q.arm && !busy && !s_q.dp) begin
            case (s_q.cmd)
                OP_WREN: s_d.wel = 1'b1;
                OP_WRDI: s_d.wel = 1'b0;
                OP_DP:   s_d.dp  = 1'b1;
                OP_WRSR: if (s_q.wel) begin
                    s_d.eng   = ENG_STAT;
                    s_d.eleft = CW'(STAT_CYCLES);
                end
                OP_PP: if (s_q.wel) begin
                    s_d.eng   = ENG_PROG;
                    s_d.eptr  = s_q.addr & ~PG_MASK;
                    s_d.eleft = CW'(PAGE_BYTES);
                end
                OP_SE: if (s_q.wel) begin
                    s_d.eng   = ENG_ERASE;
                    s_d.eptr  = s_q.addr & ~SEC_MASK;
                    s_d.eleft = CW'(SECTOR_BYTES);
                end
                OP_BE: if (s_q.wel) begin
                    s_d.eng   = ENG_ERASE;
                    s_d.eptr  = s_q.addr & ~BLK_MASK;
                    s_d.eleft = CW'(BLOCK_BYTES);
                end
                default: ;
            endcase
        end

        if (!sel) begin
            s_d.ph   = PH_OP;
            s_d.acnt = '0;
            s_d.tx   = '0;
            s_d.arm  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/spi_flash_checker.sv
module spi_flash_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wip,
    input logic       wel,
    input logic       dp,
    input logic       mem_we,
    input logic       prog_mode,
    input logic [7:0] mem_wdata,
    input logic [7:0] mem_old
);
    AST_STORE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wip); // R9
    AST_CYCLE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> wel); // R8
    AST_CYCLE_END_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel); // R9
    AST_SLEEP_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dp) |-> !wip); // R10
    AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && prog_mode) |-> ((mem_wdata & ~mem_old) == 8'h00)); // R5
endmodule

bind spi_flash_slave spi_flash_checker i_chk (
    .clk(clk), .rst_n(rst_n), .wip(busy), .wel(s_q.wel), .dp(s_q.dp),
    .mem_we(mem_we), .prog_mode(prog_active), .mem_wdata(mem_wdata),
    .mem_old(mem_rdata)
);

// File: tb/test_spi_flash_slave.sv
`timescale 1ns/1ps
module test_spi_flash_slave;
    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic mode3 = 1'b0;
    int   n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    spi_flash_slave i_spi_flash_slave (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    // {addr[10:0], program data, expected read-back}
    localparam logic [26:0] VEC [8] = '{
        {11'h205, 8'hA5, 8'hA5},
        {11'h206, 8'h3C, 8'h3C},
        {11'h205, 8'h0F, 8'h05},
        {11'h010, 8'hFF, 8'hFF},
        {11'h011, 8'h00, 8'h00},
        {11'h7FF, 8'h81, 8'h81},
        {11'h400, 8'h5A, 8'h5A},
        {11'h010, 8'hF0, 8'hF0}
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic sel();
        sck = mode3;
        wait_clk(2);
        cs_n = 1'b0;
        wait_clk(6);
    endtask

    task automatic desel();
        wait_clk(4);
        if (!mode3) sck = 1'b0;
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic xbits(input logic [7:0] d, input int n, output logic [7:0] r);
        r = '0;
        for (int i = 7; i > 7 - n; i--) begin
            sck  = 1'b0;
            mosi = d[i];
            wait_clk(8);
            r[i] = miso;
            sck  = 1'b1;
            wait_clk(8);
        end
    endtask

    task automatic send(input logic [7:0] d);
        logic [7:0] r;
        xbits(d, 8, r);
    endtask

    task automatic send_addr(input logic [10:0] a);
        send(8'h00);
        send({5'd0, a[10:8]});
        send(a[7:0]);
    endtask

    task automatic simple(input logic [7:0] op);
        sel(); send(op); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        sel(); send(8'h05); xbits(8'h00, 8, s); desel();
    endtask

    task automatic read1(input logic [10:0] a, output logic [7:0] d);
        sel(); send(8'h03); send_addr(a); xbits(8'h00, 8, d); desel();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 100; k++) begin
            rdsr(s);
            if (!s[0]) return;
        end
        check("R9 cycle never ended", 8'h01, 8'h00);
    endtask

    task automatic erase(input logic [7:0] op, input logic [10:0] a);
        sel(); send(op); send_addr(a); desel();
    endtask

    task automatic prog1(input logic [10:0] a, input logic [7:0] d);
        simple(8'h06);
        sel(); send(8'h02); send_addr(a); send(d); desel();
        wait_idle();
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v, w;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R1: reset state
        rdsr(v); check("R1 status after reset", v, 8'h00);

        // R7/R9: block erases clear the whole array; busy visible
        simple(8'h06); erase(8'hD8, 11'h000);
        rdsr(v); check("R9 busy during block erase", v, 8'h03);
        wait_idle();
        rdsr(v); check("R9 status after cycle", v, 8'h00);
        simple(8'h06); erase(8'hD8, 11'h5A5); wait_idle();
        read1(11'h000, v); check("R7 block erase low", v, 8'hFF);
        read1(11'h7FF, v); check("R7 block erase high", v, 8'hFF);

        // R3: write enable / disable
        simple(8'h06); rdsr(v); check("R3 WEL set", v, 8'h02);
        simple(8'h04); rdsr(v); check("R3 WEL clear", v, 8'h00);

        // R4: status repeats
        simple(8'h06);
        sel(); send(8'h05);
        for (int k = 0; k < 3; k++) begin
            xbits(8'h00, 8, v); check("R4 repeated status", v, 8'h02);
        end
        desel();
        simple(8'h04);

        // R2 R5: table of program / read-back vectors
        for (int i = 0; i < 8; i++) begin
            prog1(VEC[i][26:16], VEC[i][15:8]);
            read1(VEC[i][26:16], v);
            check("R2 R5 program and read back", v, VEC[i][7:0]);
        end

        // R2: sequential read across two bytes
        sel(); send(8'h03); send_addr(11'h205);
        xbits(8'h00, 8, v); xbits(8'h00, 8, w); desel();
        check("R2 sequential byte 0", v, 8'h05);
        check("R2 sequential byte 1", w, 8'h3C);

        // R5: program aborted by ragged deselect
        simple(8'h06);
        sel(); send(8'h02); send_addr(11'h040); send(8'h00); xbits(8'hFF, 3, v); desel();
        wait_clk(20);
        rdsr(v); check("R5 ragged program keeps WEL", v, 8'h02);
        read1(11'h040, v); check("R5 ragged program no write", v, 8'hFF);
        simple(8'h04);

        // R6: wrap inside page
        simple(8'h06);
        sel(); send(8'h02); send_addr(11'h1FE); send(8'h11); send(8'h22); send(8'h33); desel();
        wait_idle();
        read1(11'h1FE, v); check("R6 page byte FE", v, 8'h11);
        read1(11'h1FF, v); check("R6 page byte FF", v, 8'h22);
        read1(11'h100, v); check("R6 wrapped to page start", v, 8'h33);

        // R7: sector erase boundary rule and range
        simple(8'h06);
        sel(); send(8'h20); send_addr(11'h1FF); xbits(8'h00, 4, v); desel();
        wait_clk(20);
        rdsr(v); check("R7 ragged erase keeps WEL", v, 8'h02);
        read1(11'h100, v); check("R7 ragged erase no effect", v, 8'h33);
        erase(8'h20, 11'h1FF); wait_idle();
        read1(11'h100, v); check("R7 sector erased", v, 8'hFF);
        read1(11'h010, v); check("R7 sector erased low", v, 8'hFF);
        read1(11'h205, v); check("R7 next sector untouched", v, 8'h05);

        // R8: program without write enable
        sel(); send(8'h02); send_addr(11'h300); send(8'h00); desel();
        wait_clk(20);
        rdsr(v); check("R8 no cycle without WEL", v, 8'h00);
        read1(11'h300, v); check("R8 array unchanged", v, 8'hFF);

        // R10: deep power-down and release
        simple(8'h06); simple(8'hB9);
        rdsr(v); check("R10 status ignored in power-down", v, 8'h00);
        simple(8'h04);
        sel(); send(8'hAB);
        xbits(8'h00, 8, v); check("R10 ID first", v, 8'h13);
        xbits(8'h00, 8, v); check("R10 ID repeated", v, 8'h13);
        desel();
        rdsr(v); check("R10 disable ignored while asleep", v, 8'h02);
        simple(8'h04);

        // R10 R9: power-down while busy is ignored; cycle survives deselects
        simple(8'h06); erase(8'h20, 11'h400); simple(8'hB9);
        rdsr(v); check("R9 busy after ignored sleep", v, 8'h03);
        wait_idle();
        rdsr(v); check("R10 awake after busy sleep request", v, 8'h00);
        read1(11'h400, v); check("R9 erase completed", v, 8'hFF);

        // R11: status write
        simple(8'h06);
        sel(); send(8'h01); send(8'hA8); desel();
        rdsr(v); check("R11 busy during status write", v, 8'h03);
        wait_idle();
        rdsr(v); check("R11 status bits written", v, 8'hA8);
        simple(8'h06);
        sel(); send(8'h01); send(8'h00); desel();
        wait_idle();
        rdsr(v); check("R11 status bits restored", v, 8'h00);

        // R2: mode 3 clocking
        mode3 = 1'b1;
        wait_clk(4);
        read1(11'h205, v); check("R2 mode 3 read", v, 8'h05);
        rdsr(v); check("R2 mode 3 status", v, 8'h00);
        mode3 = 1'b0;

        finish_run();
    end
endmodule